// File: doc/BRIEF.md
# Early-Restart Line Fill for a Direct-Mapped Load Cache

This block is the miss path of a small direct-mapped cache that only serves loads. A load presents a word address on a valid/ready port. When its line is present the load is accepted at once and its data comes back on the following cycle. When the line is absent the cache fetches the whole line from a memory burst port. The burst begins with the word the load asked for and then wraps around the line.

The stalled load is released in the very cycle its word arrives from memory. The rest of the line keeps streaming into the array behind it. Later loads to words of that line that have already landed are served while the burst is still running. A load to a word of the filling line that has not arrived yet waits for that word. A load that misses on any other line waits until the running burst has finished. Only one burst is ever outstanding.

Addresses are word addresses. The low `log2(LINE_WORDS)` bits select the word within the line. The next `log2(LINES)` bits select the line slot. The remaining upper bits are the tag.

Top module: `lfill_cache`

## Requirements
- R1: A load whose line is complete and valid is accepted (`cpu_req_ready` high) in the cycle it is presented. `cpu_rsp_valid` pulses in the next cycle with the stored word on `cpu_rsp_data`.
- R2: A load that misses raises `mem_req_valid`. `mem_req_line` carries the address with the word bits removed (`addr >> log2(LINE_WORDS)`), and `mem_req_start` carries the word bits (`addr[log2(LINE_WORDS)-1:0]`). Both stay unchanged until `mem_req_ready` is seen.
- R3: Every burst has exactly LINE_WORDS beats. Beat k is written to word `(start + k) mod LINE_WORDS` of the line. After the burst, every word of the line hits with the data memory supplied.
- R4: The missing load is accepted in the same cycle as beat 0 of its burst, before the burst ends. Its response on the next cycle carries that beat's data.
- R5: While a burst is running, a load to a word of that line already received is accepted with no wait.
- R6: While a burst is running, a load to a word of that line not yet received waits. It is accepted in the cycle the beat carrying that word arrives.
- R7: A load that misses on a different line while a burst is running waits. Its own burst request is issued only after the last beat of the running burst, and the next burst is never requested before the previous one has delivered all its beats.
- R8: After reset no line is valid: `cpu_rsp_valid` and `mem_req_valid` are low, and the first load misses.
- R9: A burst into a slot evicts the line previously held there. A later load to the evicted tag misses and issues a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Load request present |
| cpu_req_addr | input | ADDR_W | Word address of the load, held until accepted |
| cpu_req_ready | output | 1 | Load accepted this cycle |
| cpu_rsp_valid | output | 1 | Load data valid (one cycle after acceptance) |
| cpu_rsp_data | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Line burst request |
| mem_req_ready | input | 1 | Memory takes the burst request |
| mem_req_line | output | ADDR_W-log2(LINE_WORDS) | Line address of the burst |
| mem_req_start | output | log2(LINE_WORDS) | Word index the burst starts with |
| mem_rsp_valid | input | 1 | Burst beat present |
| mem_rsp_data | input | DATA_W | Burst beat data |

## Verification
Two functions can fall in the same cycle. A burst beat is written into the array while a waiting load is released by that same beat and takes its data straight from the memory port, not from the array. The bench provokes this by presenting a load to the word carried by the last beat of a slowly paced burst, so the load sits waiting until the beat arrives. It then checks that the acceptance cycle equals the cycle of that beat and that the returned data matches. The same scheme judges the restart of the missing load against beat 0, and checks partial-line hits and the stall of a miss to another line against the beat schedule the memory model recorded.

// File: rtl/lfill_cache.sv
module lfill_cache #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 8
)(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cpu_req_valid,
  input  logic [ADDR_W-1:0]                     cpu_req_addr,
  output logic                                  cpu_req_ready,
  output logic                                  cpu_rsp_valid,
  output logic [DATA_W-1:0]                     cpu_rsp_data,
  output logic                                  mem_req_valid,
  input  logic                                  mem_req_ready,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]  mem_req_line,
  output logic [$clog2(LINE_WORDS)-1:0]         mem_req_start,
  input  logic                                  mem_rsp_valid,
  input  logic [DATA_W-1:0]                     mem_rsp_data
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL} fill_st_t;

  fill_st_t            st_q;
  logic [TAG_W-1:0]    fill_tag;
  logic [IDX_W-1:0]    fill_idx;
  logic [OFF_W-1:0]    fill_start;
  logic [OFF_W-1:0]    beat_q;
  logic [LINE_WORDS-1:0] wval_q;
  logic [LINES-1:0]    lval_q;
  logic [TAG_W-1:0]    tag_q  [LINES];
  logic [DATA_W-1:0]   data_q [LINES*LINE_WORDS];
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_data_q;

  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] beat_off;
  logic busy, on_fill, beat_now, beat_last;
  logic hit_arr, hit_part, hit_byp, start_fill, accept;

  assign req_off   = cpu_req_addr[OFF_W-1:0];
  assign req_idx   = cpu_req_addr[OFF_W +: IDX_W];
  assign req_tag   = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign beat_off  = fill_start + beat_q;
  assign busy      = (st_q != S_IDLE);
  assign beat_now  = (st_q == S_FILL) && mem_rsp_valid;
  assign beat_last = (beat_q == OFF_W'(LINE_WORDS-1));
  assign on_fill   = busy && (req_idx == fill_idx) && (req_tag == fill_tag);

  assign hit_arr  = lval_q[req_idx] && (tag_q[req_idx] == req_tag) && !(busy && req_idx == fill_idx);
  assign hit_part = on_fill && wval_q[req_off];
  assign hit_byp  = on_fill && beat_now && (beat_off == req_off);

  assign cpu_req_ready = hit_arr || hit_part || hit_byp;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign start_fill    = (st_q == S_IDLE) && cpu_req_valid && !hit_arr;

  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_line  = {fill_tag, fill_idx};
  assign mem_req_start = fill_start;
  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_data  = rsp_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      fill_tag    <= '0;
      fill_idx    <= '0;
      fill_start  <= '0;
      beat_q      <= '0;
      wval_q      <= '0;
      lval_q      <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= accept;
      case (st_q)
        S_IDLE: if (start_fill) begin
          st_q            <= S_REQ;
          fill_tag        <= req_tag;
          fill_idx        <= req_idx;
          fill_start      <= req_off;
          wval_q          <= '0;
          lval_q[req_idx] <= 1'b0;
        end
        S_REQ: if (mem_req_ready) begin
          st_q   <= S_FILL;
          beat_q <= '0;
        end
        S_FILL: if (mem_rsp_valid) begin
          wval_q[beat_off] <= 1'b1;
          beat_q           <= beat_q + 1'b1;
          if (beat_q == '0) lval_q[fill_idx] <= 1'b1;
          if (beat_last) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (beat_now) begin
      data_q[{fill_idx, beat_off}] <= mem_rsp_data;
      if (beat_q == '0) tag_q[fill_idx] <= fill_tag;
    end
    if (accept)
      rsp_data_q <= hit_byp ? mem_rsp_data : data_q[{req_idx, req_off}];
  end
endmodule

// File: rtl/lfill_cache_chk.sv
module lfill_cache_chk #(
  parameter int LINE_WORDS = 4,
  parameter int LINE_W     = 14,
  parameter int OFF_W      = 2
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [LINE_W-1:0] mem_req_line,
  input logic [OFF_W-1:0]  mem_req_start,
  input logic              mem_rsp_valid
);
  int unsigned beats;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats <= 0;
      seen  <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      beats <= 0;
      seen  <= 1'b1;
    end else if (mem_rsp_valid) begin
      beats <= beats + 1;
    end
  end

  a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> cpu_rsp_valid);

  a_r1_rsp_only_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(cpu_req_valid && cpu_req_ready));

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line) && $stable(mem_req_start));

  a_r2_req_from_stalled_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(cpu_req_valid && !cpu_req_ready));

  a_r7_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && seen |-> beats == LINE_WORDS);
endmodule

bind lfill_cache lfill_cache_chk #(
  .LINE_WORDS(LINE_WORDS),
  .LINE_W(ADDR_W - $clog2(LINE_WORDS)),
  .OFF_W($clog2(LINE_WORDS))
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_line(mem_req_line), .mem_req_start(mem_req_start),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/lfill_cache_tb.sv
`timescale 1ns/1ps
module lfill_cache_tb;
  localparam int AW = 16, DW = 32, LW = 4, NL = 8;
  localparam int OW = $clog2(LW), IW = $clog2(NL), TW = AW - OW - IW;

  logic clk = 0, rst_n = 0;
  logic cpu_req_valid = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_data;
  logic mem_req_valid, mem_req_ready;
  logic [AW-OW-1:0] mem_req_line;
  logic [OW-1:0] mem_req_start;
  logic mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;

  always #2 clk = ~clk;

  lfill_cache #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .LINES(NL)) u_dut (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
    return {TW'(tag), IW'(idx), OW'(off)};
  endfunction

  // memory model
  int mem_lat = 2, mem_gap = 0, ready_delay = 0;
  int n_req = 0, hs_cyc = 0, prev_last = 0;
  int beat_cyc [LW];
  logic [AW-OW-1:0] m_line = '0;
  logic [OW-1:0] m_start = '0;
  bit fill_done = 1;

  initial begin
    int mstate = 0, cnt = 0, beat = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      case (mstate)
        0: begin
          mem_req_ready = 0;
          if (mem_req_valid && rst_n) begin
            if (ready_delay > 0) ready_delay--;
            else begin
              mem_req_ready = 1;
              m_line = mem_req_line; m_start = mem_req_start;
              n_req++; hs_cyc = cyc; prev_last = beat_cyc[LW-1];
              cnt = mem_lat; beat = 0; fill_done = 0; mstate = 1;
            end
          end
        end
        1: begin
          mem_req_ready = 0;
          if (cnt > 0) cnt--;
          else begin
            mem_rsp_valid = 1;
            mem_rsp_data  = word_of({m_line, OW'(m_start + OW'(beat))});
            beat_cyc[beat] = cyc;
            beat++; cnt = mem_gap;
            if (beat == LW) mstate = 2;
          end
        end
        default: begin fill_done = 1; mstate = 0; end
      endcase
    end
  end

  // one load; returns wait cycles and acceptance cycle
  task automatic do_load(input logic [AW-1:0] a, input string req,
                         output int waits, output int acc);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_addr = a; waits = 0;
    forever begin
      #1;
      if (cpu_req_ready) break;
      waits++;
      @(negedge clk);
    end
    acc = cyc;
    @(negedge clk);
    cpu_req_valid = 0; cpu_req_addr = '0;
    #1;
    chk(cpu_rsp_valid == 1, req, "rsp_valid after accept", cpu_rsp_valid, 1);
    chk(cpu_rsp_data == word_of(a), req, "rsp_data", cpu_rsp_data, word_of(a));
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!fill_done);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(cpu_rsp_valid == 0, "R8", "rsp_valid after reset", cpu_rsp_valid, 0);
    chk(mem_req_valid == 0, "R8", "mem_req_valid after reset", mem_req_valid, 0);
  endtask

  // R2 R4 R5 R6 R3 on one slowly paced burst
  task automatic t_restart_and_partial();
    int w, a0, a1;
    mem_lat = 3; mem_gap = 2;
    do_load(mk(5, 2, 2), "R4", w, a0);
    chk(w > 0, "R8", "first load after reset misses", w, 1);
    chk(n_req == 1, "R2", "one burst requested", n_req, 1);
    chk(m_line == mk(5, 2, 2) >> OW, "R2", "burst line", m_line, mk(5, 2, 2) >> OW);
    chk(m_start == 2, "R2", "burst start word", m_start, 2);
    chk(a0 == beat_cyc[0], "R4", "restart on beat 0", a0, beat_cyc[0]);
    chk(fill_done == 0, "R4", "response before burst end", fill_done, 0);
    do_load(mk(5, 2, 2), "R5", w, a1);
    chk(w == 0, "R5", "received word hits during fill", w, 0);
    do_load(mk(5, 2, 3), "R5", w, a1);
    chk(w == 0, "R5", "second received word hits during fill", w, 0);
    chk(fill_done == 0, "R5", "still filling", fill_done, 0);
    do_load(mk(5, 2, 1), "R6", w, a1);
    chk(w > 0, "R6", "pending word waits", w, 1);
    chk(a1 == beat_cyc[3], "R6", "accepted on its beat", a1, beat_cyc[3]);
    wait_idle();
    for (int o = 0; o < LW; o++) begin
      do_load(mk(5, 2, o), "R3", w, a1);
      chk(w == 0, "R3", "whole line hits after fill", w, 0);
    end
    chk(n_req == 1, "R1", "no extra burst on hits", n_req, 1);
  endtask

  task automatic t_other_line();
    int w, a0, base;
    wait_idle();
    mem_lat = 1; mem_gap = 3; base = n_req;
    do_load(mk(9, 5, 1), "R4", w, a0);
    chk(a0 == beat_cyc[0], "R4", "restart on beat 0, second line", a0, beat_cyc[0]);
    do_load(mk(9, 6, 3), "R7", w, a0);
    chk(w > 0, "R7", "miss on other line waits", w, 1);
    chk(n_req == base + 2, "R7", "second burst issued", n_req, base + 2);
    chk(hs_cyc > prev_last, "R7", "request after last beat", hs_cyc, prev_last + 1);
    chk(m_start == 3, "R7", "second burst start word", m_start, 3);
    chk(a0 == beat_cyc[0], "R7", "second load restarts on its beat 0", a0, beat_cyc[0]);
  endtask

  task automatic t_conflict();
    int w, a0, base;
    wait_idle();
    mem_lat = 0; mem_gap = 0; base = n_req; ready_delay = 3;
    do_load(mk(6, 2, 0), "R9", w, a0);
    chk(w > 3, "R2", "waits through held request", w, 4);
    chk(n_req == base + 1, "R9", "conflicting tag misses", n_req, base + 1);
    chk(m_start == 0, "R2", "start word 0", m_start, 0);
    wait_idle();
    do_load(mk(5, 2, 2), "R9", w, a0);
    chk(w > 0, "R9", "evicted line misses", w, 1);
    chk(n_req == base + 2, "R9", "evicted line refetched", n_req, base + 2);
    wait_idle();
    do_load(mk(5, 2, 0), "R1", w, a0);
    chk(w == 0, "R1", "refilled line hits", w, 0);
    do_load(mk(9, 5, 3), "R1", w, a0);
    chk(w == 0, "R1", "untouched slot still hits", w, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_restart_and_partial();
    t_other_line();
    t_conflict();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule